// File: doc/BRIEF.md
# One-Bit Jump Target Predictor

This block keeps a small, fully associative table of conditional-jump records. Each record holds a jump's instruction address and the next fetch address last seen for it. When the front end issues a jump, it presents the jump address on the lookup port. In the same cycle the block returns the next fetch address it predicts. If no record matches, it predicts fall-through, which is the jump address plus one.

The reorder buffer drives the update port only when a speculation turns out wrong. It supplies the jump address and the next address that was actually taken. That address may be the branch target or the fall-through address. The matching record is overwritten, or a new record is allocated. The stored address therefore repeats the last observed outcome and flips after one wrong outcome, which makes it a one-bit history. A correct prediction causes no update, so the record stays as it is.

Top module: `btb_onebit`

## Requirements
- R1: After reset every record is empty, so every lookup misses (`lkp_hit_o` = 0).
- R2: A lookup whose address matches a stored record returns that record's target on `lkp_target_o` with `lkp_hit_o` = 1 in the same cycle, with no clock edge in between.
- R3: A lookup that misses returns `lkp_addr_i + 1` modulo 2^ADDR_W, so 16'hFFFF predicts 16'h0000.
- R4: An update whose address is already stored overwrites only that record's target. No record is allocated or evicted.
- R5: An update whose address is not stored, while any record is empty, fills the lowest-numbered empty record. The address hits from the next cycle on.
- R6: An update whose address is not stored, while all records are full, replaces records in round-robin order starting at record 0. With 4 records, the fifth distinct address evicts the first one allocated and the sixth evicts the second.
- R7: When a lookup and an update name the same address in one cycle, the lookup returns the old prediction (old target, or fall-through if it was absent). The new target is seen from the next cycle.
- R8: Lookups never change the stored records. A prediction repeats the last written outcome until an update changes it.
- R9: With `upd_valid_i` = 0, the values on `upd_addr_i` and `upd_target_i` have no effect on any later lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lkp_addr_i | input | ADDR_W | Address of the jump being issued |
| lkp_target_o | output | ADDR_W | Predicted next fetch address |
| lkp_hit_o | output | 1 | Lookup matched a stored record |
| upd_valid_i | input | 1 | Misprediction correction strobe |
| upd_addr_i | input | ADDR_W | Address of the mispredicted jump |
| upd_target_i | input | ADDR_W | Actual next fetch address |

## Verification
The assertions check the following on every cycle:
- No two records ever hold the same address.
- Records are never written while the update strobe is low.
- A rewrite of a stored address leaves every tag and valid bit untouched.
- Once a record is valid it stays valid.
- The replacement pointer moves exactly once per eviction and holds otherwise.

Only the bench's scenarios show the externally visible sequences. These are:
- the fall-through wrap at the top address,
- which older jump a full table gives up, in round-robin order,
- the same-cycle lookup that still returns the old outcome,
- a long random mix of lookups and corrections compared against a reference table.

// File: rtl/btb_pkg.sv
package btb_pkg;
  parameter int unsigned BTB_ENTRIES_DEF = 4;
  parameter int unsigned BTB_ADDR_W_DEF  = 16;

  typedef enum logic [1:0] {
    UPD_NONE    = 2'd0,
    UPD_REWRITE = 2'd1,
    UPD_FILL    = 2'd2,
    UPD_EVICT   = 2'd3
  } upd_kind_e;
endpackage

// File: rtl/btb_match.sv
module btb_match #(
  parameter int unsigned N  = 4,
  parameter int unsigned AW = 16
) (
  input  logic [N-1:0]         valid_i,
  input  logic [N-1:0][AW-1:0] tag_i,
  input  logic [AW-1:0]        addr_i,
  output logic [N-1:0]         hit_vec_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec_o[g] = valid_i[g] && (tag_i[g] == addr_i);
  end
endmodule

// File: rtl/btb_victim.sv
module btb_victim
  import btb_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         upd_valid_i,
  input  logic [N-1:0] hit_vec_i,
  input  logic [N-1:0] valid_i,
  output upd_kind_e    kind_o,
  output logic [N-1:0] wr_sel_o
);
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_found;

  // lowest-numbered empty slot
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (!upd_valid_i)     kind_o = UPD_NONE;
    else if (|hit_vec_i)  kind_o = UPD_REWRITE;
    else if (free_found)  kind_o = UPD_FILL;
    else                  kind_o = UPD_EVICT;
  end

  always_comb begin
    unique case (kind_o)
      UPD_REWRITE: wr_sel_o = hit_vec_i;
      UPD_FILL:    wr_sel_o = ONE << free_idx;
      UPD_EVICT:   wr_sel_o = ONE << ptr_q;
      default:     wr_sel_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ptr_q <= '0;
    else if (kind_o == UPD_EVICT) ptr_q <= (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
  end

  a_r6_ptr_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_o == UPD_EVICT |=>
      ptr_q == (($past(ptr_q) == LAST_IDX) ? '0 : $past(ptr_q) + 1'b1));

  a_r6_ptr_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_o != UPD_EVICT |=> $stable(ptr_q));

  a_r4_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel_o));
endmodule

// File: rtl/btb_onebit.sv
module btb_onebit
  import btb_pkg::*;
#(
  parameter int unsigned ENTRIES = BTB_ENTRIES_DEF,
  parameter int unsigned ADDR_W  = BTB_ADDR_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lkp_addr_i,
  output logic [ADDR_W-1:0] lkp_target_o,
  output logic              lkp_hit_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  logic [ADDR_W-1:0] upd_target_i
);
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] tgt_q;
  logic [ENTRIES-1:0]             lkp_hit_vec;
  logic [ENTRIES-1:0]             upd_hit_vec;
  logic [ENTRIES-1:0]             wr_sel;
  upd_kind_e                      upd_kind;
  logic [ADDR_W-1:0]              hit_tgt;

  btb_match #(.N(ENTRIES), .AW(ADDR_W)) u_lkp_match (
    .valid_i  (valid_q),
    .tag_i    (tag_q),
    .addr_i   (lkp_addr_i),
    .hit_vec_o(lkp_hit_vec)
  );

  btb_match #(.N(ENTRIES), .AW(ADDR_W)) u_upd_match (
    .valid_i  (valid_q),
    .tag_i    (tag_q),
    .addr_i   (upd_addr_i),
    .hit_vec_o(upd_hit_vec)
  );

  btb_victim #(.N(ENTRIES)) u_victim (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_valid_i(upd_valid_i),
    .hit_vec_i  (upd_hit_vec),
    .valid_i    (valid_q),
    .kind_o     (upd_kind),
    .wr_sel_o   (wr_sel)
  );

  // tags are unique, so an OR of the masked targets is the read mux
  always_comb begin
    hit_tgt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lkp_hit_vec[i]) hit_tgt |= tgt_q[i];
    end
  end

  assign lkp_hit_o    = |lkp_hit_vec;
  assign lkp_target_o = lkp_hit_o ? hit_tgt : lkp_addr_i + 1'b1;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
        tgt_q[g]   <= '0;
      end else if (wr_sel[g]) begin
        valid_q[g] <= 1'b1;
        tag_q[g]   <= upd_addr_i;
        tgt_q[g]   <= upd_target_i;
      end
    end
  end

  a_r2_unique_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lkp_hit_vec));

  a_r9_idle_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(valid_q) && $stable(tag_q) && $stable(tgt_q));

  a_r4_rewrite_keeps_tags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_kind == UPD_REWRITE |=> $stable(valid_q) && $stable(tag_q));

  a_r8_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (valid_q & $past(valid_q)) == $past(valid_q));

  a_r5_update_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> $countones(valid_q) >= 1);
endmodule

// File: tb/btb_onebit_tb_top.sv
module btb_onebit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] lkp_addr_i = '0;
  logic [AW-1:0] lkp_target_o;
  logic          lkp_hit_o;
  logic          upd_valid_i = 1'b0;
  logic [AW-1:0] upd_addr_i = '0;
  logic [AW-1:0] upd_target_i = '0;

  int checks = 0;
  int errors = 0;

  logic          m_valid [N];
  logic [AW-1:0] m_tag   [N];
  logic [AW-1:0] m_tgt   [N];
  int            m_ptr;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  btb_onebit #(.ENTRIES(N), .ADDR_W(AW)) dut_i (
    .clk_i, .rst_ni, .lkp_addr_i, .lkp_target_o, .lkp_hit_o,
    .upd_valid_i, .upd_addr_i, .upd_target_i
  );

  function automatic logic exp_hit(logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_valid[i] && m_tag[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [AW-1:0] exp_tgt(logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_valid[i] && m_tag[i] == a) return m_tgt[i];
    return a + 16'd1;
  endfunction

  task automatic model_update(logic [AW-1:0] a, logic [AW-1:0] t);
    int slot;
    slot = -1;
    for (int i = 0; i < N; i++) if (m_valid[i] && m_tag[i] == a) slot = i;
    if (slot < 0)
      for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) slot = i;
    if (slot < 0) begin
      slot  = m_ptr;
      m_ptr = (m_ptr + 1) % N;
    end
    m_valid[slot] = 1'b1;
    m_tag[slot]   = a;
    m_tgt[slot]   = t;
  endtask

  // one cycle: drive at negedge, check before posedge, advance model after it
  task automatic step(string req, logic [AW-1:0] la, logic uv,
                      logic [AW-1:0] ua, logic [AW-1:0] ut);
    logic          eh;
    logic [AW-1:0] et;
    @(negedge clk_i);
    lkp_addr_i   = la;
    upd_valid_i  = uv;
    upd_addr_i   = ua;
    upd_target_i = ut;
    #1;
    eh = exp_hit(la);
    et = exp_tgt(la);
    checks++;
    if (lkp_hit_o !== eh || lkp_target_o !== et) begin
      errors++;
      $display("FAIL %s addr=%h hit=%b target=%h expected hit=%b target=%h",
               req, la, lkp_hit_o, lkp_target_o, eh, et);
    end
    @(posedge clk_i);
    #1;
    if (uv) model_update(ua, ut);
  endtask

  task automatic look(string req, logic [AW-1:0] la);
    step(req, la, 1'b0, 16'h0, 16'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0;
    end
    m_ptr = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    look("R1", 16'h1234);
    look("R1", 16'h0000);
    look("R3", 16'hFFFF);
    look("R3", 16'h7FFF);

    step("R5", 16'h0010, 1'b1, 16'h0010, 16'h0040);
    look("R2", 16'h0010);
    step("R7", 16'h0010, 1'b1, 16'h0010, 16'h0011);
    look("R7", 16'h0010);
    step("R7", 16'h0020, 1'b1, 16'h0020, 16'h0300);
    look("R7", 16'h0020);
    repeat (3) look("R8", 16'h0010);
    step("R9", 16'h0010, 1'b0, 16'h0010, 16'h9999);
    step("R9", 16'h0010, 1'b0, 16'h0050, 16'h8888);
    look("R9", 16'h0050);

    step("R5", 16'h0000, 1'b1, 16'h0030, 16'h0031);
    step("R5", 16'h0000, 1'b1, 16'h0040, 16'h0100);
    look("R5", 16'h0040);
    step("R6", 16'h0000, 1'b1, 16'h0050, 16'h0500);
    look("R6", 16'h0010);
    look("R6", 16'h0020);
    step("R6", 16'h0000, 1'b1, 16'h0060, 16'h0600);
    look("R6", 16'h0020);
    look("R6", 16'h0030);
    step("R4", 16'h0000, 1'b1, 16'h0040, 16'h0041);
    look("R4", 16'h0040);
    look("R4", 16'h0030);
    look("R4", 16'h0050);
    look("R4", 16'h0060);

    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] la, ua, ut;
      logic          uv;
      la = 16'h0100 + 16'($urandom_range(0, 7));
      uv = ($urandom_range(0, 3) == 0);
      ua = ($urandom_range(0, 3) == 0) ? la : 16'h0100 + 16'($urandom_range(0, 7));
      ut = ($urandom_range(0, 1) == 0) ? ua + 16'd1 : 16'($urandom);
      step(exp_hit(la) ? "R2" : "R3", la, uv, ua, ut);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule